// File: doc/BRIEF.md
# Shared-Bus Register, ALU and Memory Datapath

This block is a small 4-bit datapath. One shared bus links an external input port, a 16-word scratch memory and an arithmetic unit. Whatever value is on the bus can be stored in a register bank of eight entries, in a memory address register, in the memory, or in an output register. The register bank has one decoded write port and two independent read ports. The two read ports feed the arithmetic unit. The unit's result passes through a combinational shift stage before it reaches the bus.

No sequencer is included. Every enable, address and operation code is a top-level input, so an external controller or a testbench builds each transfer one cycle at a time. Each transfer completes in a single clock. The supported transfers are: an operation on two registers written back to any register, memory to register, memory to output, register to memory (by passing the register through the arithmetic unit), and input to any destination.

Top module: `bus_datapath`

## Requirements
- R1: A synchronous active-high reset clears all eight registers, the memory address register and `out_data` to zero. Memory contents are not reset.
- R2: When `rf_we` is 1, the bus value is written on the clock edge into the register selected by the 3-bit `rf_wa` only, and every other register keeps its value.
- R3: When `rf_we` is 0, no register changes, whatever the values of `rf_wa` and the bus.
- R4: The two read ports `rf_ra1` (operand A) and `rf_ra2` (operand B) select registers independently in the same cycle, and both may name the same register.
- R5: `alu_op` encodes: 000 A, 001 B, 010 all zeros, 011 all ones, 100 A+B, 101 A-B, 110 A AND B, 111 A OR B. Sums and differences wrap modulo 16.
- R6: `shift_mode` acts on the arithmetic result before it reaches the bus: 00 and 01 pass the result unchanged, 10 shifts left with a 0 entering bit 0, 11 shifts right with a 0 entering bit 3.
- R7: The bus carries `in_data` when `in_en` is 1, the memory read data when `mem_en` is 1, and the shifted arithmetic result when `alu_en` is 1. It is zero when no enable is set.
- R8: `out_data` is registered. It takes the bus value on a clock edge where `out_we` is 1 and holds its value otherwise.
- R9: `mar_ld` loads the memory address register from the bus. `mem_wr` writes the bus into the word at that address on the clock edge. While `mem_rd` is 1, the read data is the addressed word in the same cycle; while `mem_rd` is 0, the read data is zero.
- R10: At most one of `in_en`, `mem_en` and `alu_en` may be 1 in any cycle. Enabling each source alone gives exactly that source on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 4 | External input value |
| in_en | input | 1 | Input port drives the bus |
| mem_en | input | 1 | Memory read data drives the bus |
| alu_en | input | 1 | Shifted arithmetic result drives the bus |
| rf_we | input | 1 | Register bank write enable |
| rf_wa | input | 3 | Register write address |
| rf_ra1 | input | 3 | Operand A read address |
| rf_ra2 | input | 3 | Operand B read address |
| alu_op | input | 3 | Arithmetic operation code |
| shift_mode | input | 2 | Shift stage mode |
| mar_ld | input | 1 | Load the memory address register from the bus |
| mem_rd | input | 1 | Memory read enable |
| mem_wr | input | 1 | Memory write enable |
| out_we | input | 1 | Output register load enable |
| out_data | output | 4 | Registered output value |

## Verification
The assertions assume that the controller never enables two bus sources at once; a violation of this is itself flagged as an error. They also assume that a register read address which stays unchanged over a cycle with no write must return the same value. The stimulus sets every control at the falling edge from a cleared default, so each cycle enables at most one source. The stimulus reads memory only at addresses it has already written, so the memory's unreset contents never reach a checked output.

// File: rtl/dp_pkg.sv
package dp_pkg;

  typedef enum logic [2:0] {
    OP_PASS_A = 3'b000,
    OP_PASS_B = 3'b001,
    OP_ZERO   = 3'b010,
    OP_ONES   = 3'b011,
    OP_ADD    = 3'b100,
    OP_SUB    = 3'b101,
    OP_AND    = 3'b110,
    OP_OR     = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_HOLD  = 2'b00,
    SH_LOAD  = 2'b01,
    SH_LEFT  = 2'b10,
    SH_RIGHT = 2'b11
  } shift_mode_e;

endpackage

// File: rtl/dp_regbank.sv
module dp_regbank #(
  parameter int DW = 4,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2
);
  localparam int NREG = 1 << AW;

  logic [NREG-1:0] load_vec;
  logic [DW-1:0]   regs [NREG];

  // decoder: one load strobe, only while writing
  always_comb begin
    load_vec = '0;
    if (we) load_vec[wa] = 1'b1;
  end

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)              regs[i] <= '0;
        else if (load_vec[i]) regs[i] <= wd;
      end
    end
  endgenerate

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [2:0]    op,
  output logic [DW-1:0] y
);
  logic [DW-1:0] grp_pass, grp_const, grp_arith, grp_logic;

  // low bit chooses within a pair, upper two bits choose the pair
  always_comb begin
    grp_pass  = op[0] ? b : a;
    grp_const = op[0] ? {DW{1'b1}} : {DW{1'b0}};
    grp_arith = op[0] ? (a - b) : (a + b);
    grp_logic = op[0] ? (a | b) : (a & b);
    case (op[2:1])
      2'b00:   y = grp_pass;
      2'b01:   y = grp_const;
      2'b10:   y = grp_arith;
      default: y = grp_logic;
    endcase
  end
endmodule

// File: rtl/dp_shift.sv
module dp_shift
  import dp_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic [DW-1:0] d,
  input  logic [1:0]    mode,
  output logic [DW-1:0] q
);
  always_comb begin
    case (shift_mode_e'(mode))
      SH_LEFT:  q = {d[DW-2:0], 1'b0};
      SH_RIGHT: q = {1'b0, d[DW-1:1]};
      default:  q = d;
    endcase
  end
endmodule

// File: rtl/dp_mem.sv
module dp_mem #(
  parameter int DW = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rq
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[addr] <= wd;
  end

  assign rq = re ? ram[addr] : '0;
endmodule

// File: rtl/bus_datapath.sv
module bus_datapath
  import dp_pkg::*;
#(
  parameter int DW  = 4,
  parameter int RAW = 3,
  parameter int MAW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  in_data,
  input  logic           in_en,
  input  logic           mem_en,
  input  logic           alu_en,
  input  logic           rf_we,
  input  logic [RAW-1:0] rf_wa,
  input  logic [RAW-1:0] rf_ra1,
  input  logic [RAW-1:0] rf_ra2,
  input  logic [2:0]     alu_op,
  input  logic [1:0]     shift_mode,
  input  logic           mar_ld,
  input  logic           mem_rd,
  input  logic           mem_wr,
  input  logic           out_we,
  output logic [DW-1:0]  out_data
);
  logic [DW-1:0]  rd_a, rd_b, alu_y, sh_y, mem_q, bus;
  logic [MAW-1:0] mar_q;

  dp_regbank #(.DW(DW), .AW(RAW)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .wa(rf_wa), .wd(bus),
    .ra1(rf_ra1), .ra2(rf_ra2), .rd1(rd_a), .rd2(rd_b)
  );

  dp_alu #(.DW(DW)) u_alu (.a(rd_a), .b(rd_b), .op(alu_op), .y(alu_y));

  dp_shift #(.DW(DW)) u_sh (.d(alu_y), .mode(shift_mode), .q(sh_y));

  dp_mem #(.DW(DW), .AW(MAW)) u_mem (
    .clk(clk), .we(mem_wr), .re(mem_rd), .addr(mar_q), .wd(bus), .rq(mem_q)
  );

  // one-hot selected bus in place of shared tri-state drivers
  always_comb begin
    bus = ({DW{in_en}}  & in_data)
        | ({DW{mem_en}} & mem_q)
        | ({DW{alu_en}} & sh_y);
  end

  always_ff @(posedge clk) begin
    if (rst)         mar_q <= '0;
    else if (mar_ld) mar_q <= MAW'(bus);
  end

  always_ff @(posedge clk) begin
    if (rst)         out_data <= '0;
    else if (out_we) out_data <= bus;
  end
endmodule

// File: rtl/bus_datapath_chk.sv
module bus_datapath_chk #(
  parameter int DW  = 4,
  parameter int RAW = 3,
  parameter int MAW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           in_en,
  input logic           mem_en,
  input logic           alu_en,
  input logic [DW-1:0]  in_data,
  input logic           rf_we,
  input logic [RAW-1:0] rf_ra1,
  input logic [DW-1:0]  rd_a,
  input logic           mar_ld,
  input logic [MAW-1:0] mar_q,
  input logic [DW-1:0]  bus,
  input logic           out_we,
  input logic [DW-1:0]  out_data
);
  p_onehot_src_r10: assert property (@(posedge clk) disable iff (rst)
    $countones({in_en, mem_en, alu_en}) <= 1);

  p_idle_bus_r7: assert property (@(posedge clk) disable iff (rst)
    !(in_en || mem_en || alu_en) |-> bus == '0);

  p_in_bus_r7: assert property (@(posedge clk) disable iff (rst)
    (in_en && !mem_en && !alu_en) |-> bus == in_data);

  p_out_load_r8: assert property (@(posedge clk) disable iff (rst)
    out_we |=> out_data == $past(bus));

  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !out_we |=> $stable(out_data));

  p_mar_load_r9: assert property (@(posedge clk) disable iff (rst)
    mar_ld |=> mar_q == MAW'($past(bus)));

  p_rf_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rf_we |=> (rf_ra1 != $past(rf_ra1)) || $stable(rd_a));
endmodule

bind bus_datapath bus_datapath_chk #(.DW(DW), .RAW(RAW), .MAW(MAW)) u_chk (
  .clk(clk), .rst(rst), .in_en(in_en), .mem_en(mem_en), .alu_en(alu_en),
  .in_data(in_data), .rf_we(rf_we), .rf_ra1(rf_ra1), .rd_a(rd_a),
  .mar_ld(mar_ld), .mar_q(mar_q), .bus(bus), .out_we(out_we),
  .out_data(out_data)
);

// File: tb/tb_bus_datapath.sv
`timescale 1ns/1ps
module tb_bus_datapath;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] in_data;
  logic       in_en, mem_en, alu_en, rf_we, mar_ld, mem_rd, mem_wr, out_we;
  logic [2:0] rf_wa, rf_ra1, rf_ra2, alu_op;
  logic [1:0] shift_mode;
  logic [3:0] out_data;

  always #5 clk = ~clk;

  bus_datapath dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_en(in_en), .mem_en(mem_en),
    .alu_en(alu_en), .rf_we(rf_we), .rf_wa(rf_wa), .rf_ra1(rf_ra1),
    .rf_ra2(rf_ra2), .alu_op(alu_op), .shift_mode(shift_mode),
    .mar_ld(mar_ld), .mem_rd(mem_rd), .mem_wr(mem_wr), .out_we(out_we),
    .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [3:0] val;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  logic [3:0] m_rf [8];
  logic [3:0] m_mem [16];
  logic [3:0] m_mar;

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] f_alu(logic [2:0] op, logic [3:0] a, logic [3:0] b);
    case (op)
      3'd0: return a;
      3'd1: return b;
      3'd2: return 4'h0;
      3'd3: return 4'hF;
      3'd4: return a + b;
      3'd5: return a - b;
      3'd6: return a & b;
      default: return a | b;
    endcase
  endfunction

  function automatic logic [3:0] f_sh(logic [1:0] m, logic [3:0] d);
    case (m)
      2'd2: return {d[2:0], 1'b0};
      2'd3: return {1'b0, d[3:1]};
      default: return d;
    endcase
  endfunction

  task automatic clear_ctl();
    in_data = 4'h0; in_en = 0; mem_en = 0; alu_en = 0; rf_we = 0;
    rf_wa = 0; rf_ra1 = 0; rf_ra2 = 0; alu_op = 0; shift_mode = 0;
    mar_ld = 0; mem_rd = 0; mem_wr = 0; out_we = 0;
  endtask

  task automatic push(logic [3:0] v, string tag);
    exp_t e;
    e.val = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk); clear_ctl();
  endtask

  task automatic wr_in(logic [2:0] r, logic [3:0] v);
    @(negedge clk); clear_ctl();
    in_data = v; in_en = 1; rf_we = 1; rf_wa = r;
    m_rf[r] = v;
  endtask

  task automatic show(logic [2:0] op, logic [1:0] sc, logic [2:0] a,
                      logic [2:0] b, string tag);
    @(negedge clk); clear_ctl();
    alu_op = op; shift_mode = sc; rf_ra1 = a; rf_ra2 = b;
    alu_en = 1; out_we = 1;
    push(f_sh(sc, f_alu(op, m_rf[a], m_rf[b])), tag);
  endtask

  task automatic alu_wb(logic [2:0] op, logic [1:0] sc, logic [2:0] a,
                        logic [2:0] b, logic [2:0] w);
    @(negedge clk); clear_ctl();
    alu_op = op; shift_mode = sc; rf_ra1 = a; rf_ra2 = b;
    alu_en = 1; rf_we = 1; rf_wa = w;
    m_rf[w] = f_sh(sc, f_alu(op, m_rf[a], m_rf[b]));
  endtask

  task automatic in_out(logic [3:0] v, string tag);
    @(negedge clk); clear_ctl();
    in_data = v; in_en = 1; out_we = 1;
    push(v, tag);
  endtask

  task automatic set_mar(logic [3:0] v);
    @(negedge clk); clear_ctl();
    in_data = v; in_en = 1; mar_ld = 1;
    m_mar = v;
  endtask

  task automatic reg_to_mem(logic [2:0] r);
    @(negedge clk); clear_ctl();
    rf_ra1 = r; alu_op = 3'd0; alu_en = 1; mem_wr = 1;
    m_mem[m_mar] = m_rf[r];
  endtask

  task automatic mem_to_reg(logic [2:0] w);
    @(negedge clk); clear_ctl();
    mem_en = 1; mem_rd = 1; rf_we = 1; rf_wa = w;
    m_rf[w] = m_mem[m_mar];
  endtask

  task automatic mem_to_out(logic rd, string tag);
    @(negedge clk); clear_ctl();
    mem_en = 1; mem_rd = rd; out_we = 1;
    push(rd ? m_mem[m_mar] : 4'h0, tag);
  endtask

  // monitor: an edge that loaded the output is compared one half cycle later
  logic cap = 1'b0;
  always @(posedge clk) cap <= out_we && !rst;

  always @(negedge clk) begin
    if (cap) begin
      if (sb_q.size() == 0) begin
        check("scoreboard empty", out_data, 4'hx);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, out_data, e.val);
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_ctl();
    rst = 1;
    for (int i = 0; i < 8; i++) m_rf[i] = 4'h0;
    m_mar = 4'h0;
    repeat (3) @(negedge clk);
    check("R1 out after reset", out_data, 4'h0);
    rst = 0;

    // R1: every register reads zero after reset
    for (int i = 0; i < 8; i++) show(3'd0, 2'd0, 3'(i), 3'd0, "R1 reg zero");

    // R2: decoded writes, each register distinct
    for (int i = 0; i < 8; i++) wr_in(3'(i), 4'(i * 3 + 1));
    for (int i = 0; i < 8; i++) show(3'd0, 2'd0, 3'(i), 3'd0, "R2 reg value");
    wr_in(3'd5, 4'hA);
    show(3'd0, 2'd0, 3'd4, 3'd0, "R2 neighbour below held");
    show(3'd0, 2'd0, 3'd5, 3'd0, "R2 target written");
    show(3'd0, 2'd0, 3'd6, 3'd0, "R2 neighbour above held");

    // R3: bus active with address set but no write enable
    @(negedge clk); clear_ctl();
    in_data = 4'hF; in_en = 1; rf_wa = 3'd2;
    show(3'd0, 2'd0, 3'd2, 3'd0, "R3 reg unchanged without we");

    // R4: independent read ports
    show(3'd4, 2'd0, 3'd1, 3'd6, "R4 add r1 r6");
    show(3'd5, 2'd0, 3'd6, 3'd1, "R4 sub r6 r1");
    show(3'd1, 2'd0, 3'd0, 3'd7, "R4 port B alone");
    show(3'd4, 2'd0, 3'd3, 3'd3, "R4 same register twice");

    // R5: all operation codes
    for (int op = 0; op < 8; op++) show(3'(op), 2'd0, 3'd2, 3'd7, "R5 op code");
    show(3'd5, 2'd0, 3'd0, 3'd7, "R5 subtract wraps");
    alu_wb(3'd4, 2'd0, 3'd1, 3'd6, 3'd7);
    show(3'd0, 2'd0, 3'd7, 3'd0, "R5 result written back");

    // R6: shift modes on 1001 and 0110
    wr_in(3'd0, 4'h9);
    wr_in(3'd1, 4'h6);
    for (int m = 0; m < 4; m++) show(3'd0, 2'(m), 3'd0, 3'd0, "R6 shift of 9");
    for (int m = 0; m < 4; m++) show(3'd0, 2'(m), 3'd1, 3'd0, "R6 shift of 6");

    // R7 and R10: one source at a time, then none
    in_out(4'hC, "R7 input on bus");
    show(3'd3, 2'd0, 3'd0, 3'd0, "R10 alu alone on bus");
    @(negedge clk); clear_ctl();
    out_we = 1;
    push(4'h0, "R7 idle bus is zero");

    // R8: output holds when its enable is low
    in_out(4'h5, "R8 load");
    @(negedge clk); clear_ctl();
    in_data = 4'h9; in_en = 1;
    idle();
    check("R8 hold without we", out_data, 4'h5);

    // R9: address register, write, read, read gating
    set_mar(4'h3);
    reg_to_mem(3'd1);
    set_mar(4'hE);
    reg_to_mem(3'd7);
    set_mar(4'h3);
    mem_to_out(1'b1, "R9 read word 3");
    mem_to_out(1'b0, "R9 read gated to zero");
    set_mar(4'hE);
    mem_to_reg(3'd2);
    show(3'd0, 2'd0, 3'd2, 3'd0, "R9 memory to register");
    mem_to_out(1'b1, "R10 memory alone on bus");

    idle();
    idle();
    idle();
    if (sb_q.size() != 0) check("scoreboard drained", 4'(sb_q.size()), 4'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule